// File: doc/BRIEF.md
# Indirect Branch Target Predictor

This block guesses where an indirect branch will jump by remembering the last target seen for each table slot. The slots form an untagged, direct-mapped table. The slot is chosen by a field of the branch address. Each accepted request carries the branch address and the target that the branch actually resolved to. The block looks up the stored target and reports it on an observation output. It raises a mispredict flag when the stored target differs from the resolved target in any bit. It then stores the resolved target in the same slot, whether the guess was right or wrong.

No tag or valid bit is kept. Two branches that land on the same slot share one entry and overwrite each other's target, and this sharing is never detected. After reset, a sequencer writes zero into every slot, one slot per cycle. `ready` stays low until that sweep has finished. A request whose slot was written by the request accepted just before it compares against that fresh target, because the last write is forwarded to the compare stage.

Top module: `itgt_predictor`

## Requirements
- R1: While `rst` is high, and for exactly DEPTH (default 512) rising edges after it falls, `ready` is low and `resp_valid` is low. On the DEPTH-th edge `ready` goes high, and it stays high until the next reset.
- R2: A request presented while `ready` is low is ignored. It produces no response and leaves the table unchanged, so a later lookup of that slot still finds zero.
- R3: The slot index is `(req_addr >> LO_ZERO_BITS)` masked to its low IDX_BITS bits (defaults 2 and 9). Address bits below and above that field do not affect which slot is used.
- R4: `resp_pred_target` is the target stored in the slot. `resp_mispredict` is 1 exactly when that target differs from `req_target` in at least one bit.
- R5: Every accepted request writes its `req_target` into its slot, on a hit as well as on a mispredict.
- R6: All slots hold zero after the reset sweep. The first lookup of a slot therefore mispredicts unless the resolved target is zero.
- R7: Two addresses with the same index share one slot. A request sees the target left by the most recent earlier request to any address with that index.
- R8: Requests to the same slot on consecutive cycles see each other's writes. The second request compares against the target written by the first.
- R9: A request accepted on rising edge n produces `resp_valid` = 1 for one cycle after edge n+1. `resp_mispredict` and `resp_pred_target` are 0 whenever `resp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the clear sweep |
| req_valid | input | 1 | Request strobe, accepted when `ready` is high |
| req_addr | input | ADDR_W | Address of the indirect branch |
| req_target | input | TGT_W | Resolved target of the branch |
| ready | output | 1 | High once every slot has been cleared |
| resp_valid | output | 1 | Response strobe, one cycle per accepted request |
| resp_mispredict | output | 1 | Stored target differed from the resolved target |
| resp_pred_target | output | TGT_W | Stored target used as the prediction |

## Verification
Suppose a slot holds the wrong value: a write was lost, a write went to the wrong index, or the sweep skipped a slot. The fault shows on `resp_pred_target` and `resp_mispredict` at the next lookup of that slot, which may come many cycles later. A broken bypass shows only when the same slot is used on back-to-back cycles, and it shows in the response to the second request, one edge after that request is accepted. The stimulus therefore packs requests into a few slots with a small set of targets, so that hits, misses, aliases and back-to-back reuse all occur often. The reference model is updated in request order.

// File: rtl/itgt_pkg.sv
package itgt_pkg;
  // defaults shared by the block and its bench
  localparam int unsigned DEF_ADDR_W   = 32;
  localparam int unsigned DEF_TGT_W    = 32;
  localparam int unsigned DEF_IDX_BITS = 9;
  localparam int unsigned DEF_LO_ZERO  = 2;

  typedef enum logic [0:0] {
    PH_CLEAR = 1'b0,
    PH_RUN   = 1'b1
  } itgt_phase_e;
endpackage

// File: rtl/itgt_clear_seq.sv
module itgt_clear_seq #(
  parameter int unsigned IDX_BITS = 9
) (
  input  logic                clk,
  input  logic                rst,
  output logic                clr_we,
  output logic [IDX_BITS-1:0] clr_idx,
  output logic                run
);
  import itgt_pkg::*;

  localparam logic [IDX_BITS-1:0] LAST_IDX = {IDX_BITS{1'b1}};

  itgt_phase_e phase_q;
  logic [IDX_BITS-1:0] idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_CLEAR;
      idx_q   <= '0;
    end else if (phase_q == PH_CLEAR) begin
      idx_q <= idx_q + 1'b1;
      if (idx_q == LAST_IDX) phase_q <= PH_RUN;
    end
  end

  assign clr_we  = (phase_q == PH_CLEAR);
  assign clr_idx = idx_q;
  assign run     = (phase_q == PH_RUN);

  // R1
  run_sticky_chk: assert property (@(posedge clk) disable iff (rst) run |=> run);

  // R1
  run_after_last_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(run) |-> $past(idx_q) == LAST_IDX);
endmodule

// File: rtl/itgt_table.sv
module itgt_table #(
  parameter int unsigned IDX_BITS = 9,
  parameter int unsigned DATA_W   = 32
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IDX_BITS-1:0] waddr,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [IDX_BITS-1:0] raddr,
  output logic [DATA_W-1:0]   rdata
);
  localparam int unsigned DEPTH = 1 << IDX_BITS;

  logic [DATA_W-1:0] mem [DEPTH];

  // read-first simple dual-port RAM, registered read
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/itgt_resolve.sv
module itgt_resolve #(
  parameter int unsigned IDX_BITS = 9,
  parameter int unsigned TGT_W    = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                acc,
  input  logic [IDX_BITS-1:0] acc_idx,
  input  logic [TGT_W-1:0]    acc_tgt,
  input  logic [TGT_W-1:0]    rd_data,
  output logic                upd_we,
  output logic [IDX_BITS-1:0] upd_idx,
  output logic [TGT_W-1:0]    upd_tgt,
  output logic                out_valid,
  output logic                out_miss,
  output logic [TGT_W-1:0]    out_pred
);
  // lookup stage: request captured alongside the RAM read
  logic                s1_v;
  logic [IDX_BITS-1:0] s1_idx;
  logic [TGT_W-1:0]    s1_tgt;
  // bypass: the write that landed on the same edge as the s1 read
  logic                byp_v;
  logic [IDX_BITS-1:0] byp_idx;
  logic [TGT_W-1:0]    byp_tgt;

  logic             byp_hit;
  logic [TGT_W-1:0] stored;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_v   <= 1'b0;
      s1_idx <= '0;
      s1_tgt <= '0;
      byp_v  <= 1'b0;
      byp_idx <= '0;
      byp_tgt <= '0;
    end else begin
      s1_v    <= acc;
      s1_idx  <= acc_idx;
      s1_tgt  <= acc_tgt;
      byp_v   <= s1_v;
      byp_idx <= s1_idx;
      byp_tgt <= s1_tgt;
    end
  end

  assign byp_hit = byp_v && (byp_idx == s1_idx);
  assign stored  = byp_hit ? byp_tgt : rd_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_miss  <= 1'b0;
      out_pred  <= '0;
    end else begin
      out_valid <= s1_v;
      out_miss  <= s1_v && (stored != s1_tgt);
      out_pred  <= s1_v ? stored : '0;
    end
  end

  assign upd_we  = s1_v;
  assign upd_idx = s1_idx;
  assign upd_tgt = s1_tgt;

  // R9
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (!out_miss && out_pred == '0));

  // R8
  bypass_source_chk: assert property (@(posedge clk) disable iff (rst)
    byp_v |-> $past(upd_we));
endmodule

// File: rtl/itgt_predictor.sv
module itgt_predictor #(
  parameter int unsigned ADDR_W       = itgt_pkg::DEF_ADDR_W,
  parameter int unsigned TGT_W        = itgt_pkg::DEF_TGT_W,
  parameter int unsigned IDX_BITS     = itgt_pkg::DEF_IDX_BITS,
  parameter int unsigned LO_ZERO_BITS = itgt_pkg::DEF_LO_ZERO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [TGT_W-1:0]  req_target,
  output logic              ready,
  output logic              resp_valid,
  output logic              resp_mispredict,
  output logic [TGT_W-1:0]  resp_pred_target
);
  logic                clr_we;
  logic [IDX_BITS-1:0] clr_idx;
  logic                run;
  logic                acc;
  logic [IDX_BITS-1:0] req_idx;
  logic [ADDR_W-1:0]   addr_shift;
  logic                upd_we;
  logic [IDX_BITS-1:0] upd_idx;
  logic [TGT_W-1:0]    upd_tgt;
  logic                wr_en;
  logic [IDX_BITS-1:0] wr_idx;
  logic [TGT_W-1:0]    wr_data;
  logic [TGT_W-1:0]    rd_data;

  assign addr_shift = req_addr >> LO_ZERO_BITS;
  assign req_idx    = addr_shift[IDX_BITS-1:0];
  assign acc        = req_valid && run;
  assign ready      = run;

  itgt_clear_seq #(.IDX_BITS(IDX_BITS)) u_clear (
    .clk     (clk),
    .rst     (rst),
    .clr_we  (clr_we),
    .clr_idx (clr_idx),
    .run     (run)
  );

  assign wr_en   = clr_we || upd_we;
  assign wr_idx  = clr_we ? clr_idx : upd_idx;
  assign wr_data = clr_we ? '0 : upd_tgt;

  itgt_table #(.IDX_BITS(IDX_BITS), .DATA_W(TGT_W)) u_table (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_idx),
    .wdata (wr_data),
    .raddr (req_idx),
    .rdata (rd_data)
  );

  itgt_resolve #(.IDX_BITS(IDX_BITS), .TGT_W(TGT_W)) u_resolve (
    .clk       (clk),
    .rst       (rst),
    .acc       (acc),
    .acc_idx   (req_idx),
    .acc_tgt   (req_target),
    .rd_data   (rd_data),
    .upd_we    (upd_we),
    .upd_idx   (upd_idx),
    .upd_tgt   (upd_tgt),
    .out_valid (resp_valid),
    .out_miss  (resp_mispredict),
    .out_pred  (resp_pred_target)
  );

  // R1
  no_update_in_sweep_chk: assert property (@(posedge clk) disable iff (rst)
    clr_we |-> !upd_we);

  // R1
  silent_until_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !resp_valid);

  // R9
  resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    resp_valid |-> $past(req_valid && ready, 2));

  // R2
  ignored_req_no_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !ready) |=> ##1 !resp_valid);
endmodule

// File: tb/itgt_predictor_bench.sv
module itgt_predictor_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW    = 32;
  localparam int TW    = 32;
  localparam int IB    = 9;
  localparam int LZ    = 2;
  localparam int DEPTH = 1 << IB;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [TW-1:0] req_target = '0;
  logic          ready;
  logic          resp_valid;
  logic          resp_mispredict;
  logic [TW-1:0] resp_pred_target;

  itgt_predictor #(.ADDR_W(AW), .TGT_W(TW), .IDX_BITS(IB), .LO_ZERO_BITS(LZ)) u_itgt_predictor (
    .clk              (clk),
    .rst              (rst),
    .req_valid        (req_valid),
    .req_addr         (req_addr),
    .req_target       (req_target),
    .ready            (ready),
    .resp_valid       (resp_valid),
    .resp_mispredict  (resp_mispredict),
    .resp_pred_target (resp_pred_target)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;

  logic [TW-1:0] mdl [DEPTH];
  logic          pv   [2];
  logic          pmis [2];
  logic [TW-1:0] ppred[2];
  string         ptag [2];

  function automatic int idx_of(logic [AW-1:0] a);
    return int'((a >> LZ) & (DEPTH - 1));
  endfunction

  function automatic logic [AW-1:0] mk_addr(int idx, logic [AW-1:0] noise);
    return (noise & ~(AW'(DEPTH - 1) << LZ)) | (AW'(idx) << LZ);
  endfunction

  task automatic chk(bit ok, string tag, logic [TW-1:0] act, logic [TW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // one cycle: check the response due now, then drive the next request
  task automatic step(bit v, logic [AW-1:0] a, logic [TW-1:0] t, string tag);
    @(negedge clk);
    chk(resp_valid == pv[1], {"R9 valid ", ptag[1]}, TW'(resp_valid), TW'(pv[1]));
    chk(resp_mispredict == pmis[1], {"R4 mispredict ", ptag[1]}, TW'(resp_mispredict), TW'(pmis[1]));
    chk(resp_pred_target == ppred[1], {"R4 target ", ptag[1]}, resp_pred_target, ppred[1]);
    pv[1] = pv[0]; pmis[1] = pmis[0]; ppred[1] = ppred[0]; ptag[1] = ptag[0];
    req_valid  = v;
    req_addr   = a;
    req_target = t;
    ptag[0] = tag;
    if (v && ready) begin
      pv[0]    = 1'b1;
      ppred[0] = mdl[idx_of(a)];
      pmis[0]  = (mdl[idx_of(a)] != t);
      mdl[idx_of(a)] = t;   // R5: always overwritten
    end else begin
      pv[0] = 1'b0; pmis[0] = 1'b0; ppred[0] = '0;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    int sweep_n;
    logic [TW-1:0] pool [4];
    void'($urandom(32'h1d2c3b4a));
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    for (int i = 0; i < 2; i++) begin pv[i] = 0; pmis[i] = 0; ppred[i] = '0; ptag[i] = "idle"; end
    pool[0] = '0; pool[1] = 32'h0000_4000; pool[2] = 32'h8000_0010; pool[3] = 32'h0000_4001;

    // R1: reset state
    repeat (3) begin
      @(negedge clk);
      chk(ready == 1'b0, "R1 ready in reset", TW'(ready), 0);
      chk(resp_valid == 1'b0, "R1 resp_valid in reset", TW'(resp_valid), 0);
    end
    rst = 1'b0;

    // R1 sweep length; R2 request during sweep is ignored
    sweep_n = 0;
    while (!ready && sweep_n < DEPTH + 8) begin
      if (sweep_n == 10) step(1, mk_addr(5, 32'h0), 32'hdead_beef, "R2 during sweep");
      else step(0, '0, '0, "R1 sweep");
      sweep_n++;
    end
    chk(sweep_n == DEPTH, "R1 sweep length", TW'(sweep_n), TW'(DEPTH));

    // R2 + R6: slot 5 untouched, zero target hits
    step(1, mk_addr(5, 32'h0), 32'h0, "R2 slot unchanged");
    // R6: fresh slot mispredicts with nonzero target
    step(1, mk_addr(6, 32'h0), 32'h1234, "R6 first lookup");
    step(0, '0, '0, "gap");
    // R4/R5: hit, then single-bit difference
    step(1, mk_addr(6, 32'h0), 32'h1234, "R5 hit after write");
    step(1, mk_addr(7, 32'h0), 32'h0, "R6 zero target");
    step(1, mk_addr(6, 32'h0), 32'h1235, "R4 one bit differs");
    step(0, '0, '0, "gap");
    // R3: low and high address bits ignored
    step(1, mk_addr(6, 32'hfff0_0003), 32'h1235, "R3 field only");
    // R7: alias through bit above the index field
    step(1, mk_addr(6, 32'h0) | (AW'(1) << (IB + LZ)), 32'h7777, "R7 alias write");
    step(0, '0, '0, "gap");
    step(1, mk_addr(6, 32'h0), 32'h1235, "R7 alias seen");
    // R8: back-to-back same slot
    step(1, mk_addr(9, 32'h0), 32'haaaa, "R8 b2b first");
    step(1, mk_addr(9, 32'h1), 32'hbbbb, "R8 b2b second");
    step(1, mk_addr(9, 32'h2), 32'hbbbb, "R8 b2b third");
    step(1, mk_addr(10, 32'h0), 32'hcccc, "R8 other slot");
    step(1, mk_addr(9, 32'h0), 32'hbbbb, "R8 after gap");

    // random traffic over few slots and few targets
    for (int k = 0; k < 4000; k++) begin
      logic [AW-1:0] a;
      int sel;
      sel = int'($urandom % 16);
      a = mk_addr((sel < 13) ? int'($urandom % 8) : int'($urandom % DEPTH), AW'($urandom));
      step(($urandom % 4) != 0, a, pool[$urandom % 4], "R4 random");
    end
    // R1: reset again mid-run restarts the sweep
    @(negedge clk);
    rst = 1'b1;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(ready == 1'b0, "R1 ready after re-reset", TW'(ready), 0);
    rst = 1'b0;
    for (int i = 0; i < DEPTH; i++) mdl[i] = '0;
    for (int i = 0; i < 2; i++) begin pv[i] = 0; pmis[i] = 0; ppred[i] = '0; end
    sweep_n = 0;
    while (!ready && sweep_n < DEPTH + 8) begin
      step(0, '0, '0, "R1 sweep 2");
      sweep_n++;
    end
    chk(sweep_n == DEPTH, "R1 sweep 2 length", TW'(sweep_n), TW'(DEPTH));
    step(1, mk_addr(6, 32'h0), 32'h1235, "R6 cleared again");
    step(0, '0, '0, "flush");
    step(0, '0, '0, "flush");
    finish_run();
  end
endmodule